// File: doc/BRIEF.md
# NCO Phase Alignment Controller

This block decides the clock cycle in which the phase accumulators of a group of numerically controlled oscillators are reset. When every channel, or every device, receives its phase reset in the same cycle, they run in phase. Software first selects a trigger source and sets an arm bit. The controller then waits for the trigger and answers it with one single-cycle phase-reset pulse. The arm bit clears itself when the trigger is answered.

There are two trigger sources. In timing-reference mode the trigger is the next rising edge of SYSREF. When no external reference is in use, the trigger is instead a free-running internal processing tick. When the one-shot sync policy is selected, this trigger also needs a separate frame-clock (LMFC) alignment arming. In data-pattern mode the trigger is the first cycle in which the I sample equals a programmed I key and the Q sample equals a programmed Q key.

The result of each arming is kept in sticky match, pass and fail flags. A trip of the alignment also raises a maskable interrupt, which stays set until it is explicitly cleared.

Top module: `nco_phase_align`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output reads 0 after that edge. This includes the internal tick counter, which restarts at 0.
- R2: A pulse on `align_arm_set` arms the controller from the next cycle onward. Without arming, no trigger produces a pulse. Each arming yields at most one trip, and the arm clears itself on that trip. The only exception is an `align_arm_set` in the trip cycle itself, which re-arms.
- R3: With `align_mode` = 2'b01 and `ext_sysref_en` = 1, a rising edge of `sysref_in` sampled at clock edge t, while armed, drives `phase_rst` high for exactly the cycle that follows edge t.
- R4: The SYSREF edge is detected against the value sampled one clock earlier. A `sysref_in` that stays high never produces a further trigger.
- R5: With `ext_sysref_en` = 0, the timing-reference trigger is an internal tick. The tick occurs at every edge where a counter that runs from 0 to TICK_PERIOD-1 after reset is at TICK_PERIOD-1. `sysref_in` is then ignored.
- R6: With `oneshot_sync` = 1, a timing-reference trigger counts only after a pulse on `lmfc_arm_set`. That LMFC arming is used up by an alignment in mode 2'b01. With `oneshot_sync` = 0, no LMFC arming is needed.
- R7: With `align_mode` = 2'b10, a trip occurs at an edge where `smp_i` == `key_i` and `smp_q` == `key_q` at the same time, while armed. A match on only one lane does nothing.
- R8: `st_match` is set by a data-pattern alignment.
- R9: `st_pass` is set together with each `phase_rst` pulse. With `align_mode` of 2'b00 or 2'b11, a timing-reference trigger or a key hit while armed sets `st_fail`, issues no pulse and disarms.
- R10: `align_arm_set` clears `st_match`, `st_pass` and `st_fail`. A trip in the same cycle still sets its flags. `st_pass` and `st_fail` are never both 1.
- R11: Every trip (pass or fail) sets an internal interrupt status. `irq` = status AND `irq_en`. `irq_clr` clears the status, and a trip in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| align_mode | input | 2 | Trigger select: 01 timing reference, 10 data pattern, other values are invalid |
| align_arm_set | input | 1 | Pulse that arms the alignment and clears the status |
| lmfc_arm_set | input | 1 | Pulse that arms the frame-clock alignment, needed in one-shot sync |
| oneshot_sync | input | 1 | 1 selects the one-shot sync policy, 0 selects continuous |
| ext_sysref_en | input | 1 | 1 uses `sysref_in`, 0 uses the internal tick |
| sysref_in | input | 1 | External timing reference |
| key_i | input | DATA_W | Expected I pattern |
| key_q | input | DATA_W | Expected Q pattern |
| smp_i | input | DATA_W | Incoming I sample |
| smp_q | input | DATA_W | Incoming Q sample |
| irq_en | input | 1 | Interrupt mask |
| irq_clr | input | 1 | Clears the interrupt status |
| phase_rst | output | 1 | Single-cycle accumulator phase-reset pulse |
| st_match | output | 1 | Sticky: the data key was seen |
| st_pass | output | 1 | Sticky: the phase reset was issued |
| st_fail | output | 1 | Sticky: an alignment was attempted in an invalid mode |
| irq | output | 1 | Masked interrupt |

## Verification
Some properties are checked by assertions on every cycle. These are: a pulse is always preceded by an armed state, the arm drops after a pulse, pass and fail are mutually exclusive, match rises only from data-pattern mode, a used-up LMFC arming is cleared, and the interrupt status has a legal cause for every rise and every clear.

Other behaviour can only be shown by the bench's scenarios. These are the exact cycle of the pulse relative to a SYSREF edge, the absence of a retrigger while SYSREF is held high, the internal tick cadence, partial key hits, invalid-mode failures and interrupt masking. The bench checks them against a cycle-by-cycle reference model.

// File: rtl/nco_align_pkg.sv
// Shared types for the NCO phase alignment controller.
package nco_align_pkg;

    // Trigger source selection. The encoding is visible to software.
    typedef enum logic [1:0] {
        ALN_OFF  = 2'b00,
        ALN_SREF = 2'b01,
        ALN_DKEY = 2'b10,
        ALN_RSVD = 2'b11
    } aln_mode_e;

    // Sticky alignment result flags.
    typedef struct packed {
        logic match;
        logic pass;
        logic fail;
    } aln_stat_t;

endpackage

// File: rtl/nco_align_sref_src.sv
// Timing-reference trigger source.
// Purpose: produces a one-cycle event from either the rising edge of an external
// reference or an internal free-running tick, gated by the LMFC arming in one-shot mode.
// Assumes: sysref_i is already synchronous to clk; TICK_PERIOD >= 2.
module nco_align_sref_src #(
    parameter int TICK_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_i,
    input  logic ext_en_i,
    input  logic oneshot_i,
    input  logic lmfc_arm_set_i,
    input  logic consume_i,
    output logic evt_o
);
    localparam int CW = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CW-1:0] TICK_LAST = CW'(TICK_PERIOD - 1);

    logic          sysref_q;
    logic [CW-1:0] tick_cnt;
    logic          lmfc_armed_q;
    logic          raw_evt;

    // Keeps the previous reference level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sysref_q <= 1'b0;
        else        sysref_q <= sysref_i;
    end

    // Free-running counter that models the internal processing clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tick_cnt <= '0;
        else if (tick_cnt == TICK_LAST) tick_cnt <= '0;
        else                        tick_cnt <= tick_cnt + 1'b1;
    end

    // Sticky LMFC arming, used up by a timing-reference alignment.
    always_ff @(posedge clk) begin
        if (!rst_n)              lmfc_armed_q <= 1'b0;
        else if (lmfc_arm_set_i) lmfc_armed_q <= 1'b1;
        else if (consume_i)      lmfc_armed_q <= 1'b0;
    end

    // Selects the raw event and applies the one-shot gating.
    always_comb begin
        raw_evt = ext_en_i ? (sysref_i & ~sysref_q) : (tick_cnt == TICK_LAST);
        evt_o   = raw_evt & (~oneshot_i | lmfc_armed_q);
    end

    p_lmfc_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !lmfc_arm_set_i) |=> !lmfc_armed_q)
        else $error("LMFC arming survived its use");

    p_oneshot_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_i && !lmfc_armed_q) |-> !evt_o)
        else $error("one-shot event without LMFC arming");

endmodule

// File: rtl/nco_align_key_det.sv
// Data-pattern detector.
// Purpose: flags the cycle in which every lane's sample equals that lane's key.
// Assumes: samples and keys are stable around the clock edge; purely combinational.
module nco_align_key_det #(
    parameter int DATA_W = 16,
    parameter int NLANE  = 2
) (
    input  logic [NLANE*DATA_W-1:0] key_i,
    input  logic [NLANE*DATA_W-1:0] smp_i,
    output logic                    hit_o
);
    logic [NLANE-1:0] lane_hit;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        // Per-lane equality compare.
        assign lane_hit[l] = (smp_i[l*DATA_W +: DATA_W] == key_i[l*DATA_W +: DATA_W]);
    end

    assign hit_o = &lane_hit;

endmodule

// File: rtl/nco_align_ctrl.sv
// Alignment sequencer.
// Purpose: holds the arm bit, decides between firing and failing on an event,
// issues the registered phase-reset pulse and keeps the sticky result flags.
// Assumes: events are already qualified single-cycle strobes.
module nco_align_ctrl
    import nco_align_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  aln_mode_e mode_i,
    input  logic      arm_set_i,
    input  logic      sref_evt_i,
    input  logic      key_hit_i,
    output logic      sref_fire_o,
    output logic      trip_o,
    output logic      phase_rst_o,
    output aln_stat_t stat_o
);
    logic      arm_q;
    logic      fire;
    logic      fail;
    logic      dkey_fire;
    aln_stat_t stat_q;
    aln_stat_t stat_d;

    // Decides what the current event means for the armed state.
    always_comb begin
        fire      = 1'b0;
        fail      = 1'b0;
        dkey_fire = 1'b0;
        if (arm_q) begin
            unique case (mode_i)
                ALN_SREF: fire = sref_evt_i;
                ALN_DKEY: begin
                    fire      = key_hit_i;
                    dkey_fire = key_hit_i;
                end
                default:  fail = sref_evt_i | key_hit_i;
            endcase
        end
        sref_fire_o = fire & (mode_i == ALN_SREF);
        trip_o      = fire | fail;
    end

    // Self-clearing arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_set_i | (arm_q & ~trip_o);
    end

    // Registered single-cycle phase-reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_rst_o <= 1'b0;
        else        phase_rst_o <= fire;
    end

    // Next value of the sticky flags: cleared by arming, then set by a trip.
    always_comb begin
        stat_d = arm_set_i ? '0 : stat_q;
        if (dkey_fire) stat_d.match = 1'b1;
        if (fire)      stat_d.pass  = 1'b1;
        if (fail)      stat_d.fail  = 1'b1;
    end

    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    p_pulse_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst_o |-> $past(arm_q))
        else $error("phase reset without arming");

    p_arm_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_rst_o && !$past(arm_set_i)) |-> !arm_q)
        else $error("arm survived a pulse");

    p_pass_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q.pass && stat_q.fail))
        else $error("pass and fail both set");

    p_match_only_dkey_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q.match) |-> ($past(mode_i) == ALN_DKEY))
        else $error("match outside data-pattern mode");

    p_fail_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q.fail) |-> !phase_rst_o)
        else $error("pulse issued on a failed alignment");

endmodule

// File: rtl/nco_align_irq.sv
// Alignment interrupt.
// Purpose: sticky trip status, masked onto the interrupt line and cleared on request.
// Assumes: trip_i is a single-cycle strobe; a trip outranks a simultaneous clear.
module nco_align_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic en_i,
    input  logic clr_i,
    output logic irq_o
);
    logic stat_q;

    // Trip-status register.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= 1'b0;
        else if (trip_i) stat_q <= 1'b1;
        else if (clr_i)  stat_q <= 1'b0;
    end

    assign irq_o = stat_q & en_i;

    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(stat_q) && stat_q) |-> $past(trip_i))
        else $error("interrupt status set without a trip");

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && !$past(trip_i)) |-> !stat_q)
        else $error("interrupt status not cleared");

endmodule

// File: rtl/nco_phase_align.sv
// NCO phase alignment controller, top level.
// Purpose: arms and triggers a one-cycle NCO phase reset from a timing reference
// or a data pattern, and reports sticky results plus an interrupt.
// Assumes: all inputs are synchronous to clk; configuration is static while armed.
module nco_phase_align
    import nco_align_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TICK_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        align_mode,
    input  logic              align_arm_set,
    input  logic              lmfc_arm_set,
    input  logic              oneshot_sync,
    input  logic              ext_sysref_en,
    input  logic              sysref_in,
    input  logic [DATA_W-1:0] key_i,
    input  logic [DATA_W-1:0] key_q,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              phase_rst,
    output logic              st_match,
    output logic              st_pass,
    output logic              st_fail,
    output logic              irq
);
    localparam int NLANE = 2;

    logic      sref_evt;
    logic      key_hit;
    logic      sref_fire;
    logic      trip;
    aln_stat_t stat;

    nco_align_sref_src #(.TICK_PERIOD(TICK_PERIOD)) u_sref (
        .clk            (clk),
        .rst_n          (rst_n),
        .sysref_i       (sysref_in),
        .ext_en_i       (ext_sysref_en),
        .oneshot_i      (oneshot_sync),
        .lmfc_arm_set_i (lmfc_arm_set),
        .consume_i      (sref_fire),
        .evt_o          (sref_evt)
    );

    nco_align_key_det #(.DATA_W(DATA_W), .NLANE(NLANE)) u_key (
        .key_i (({key_q, key_i})),
        .smp_i (({smp_q, smp_i})),
        .hit_o (key_hit)
    );

    nco_align_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (aln_mode_e'(align_mode)),
        .arm_set_i   (align_arm_set),
        .sref_evt_i  (sref_evt),
        .key_hit_i   (key_hit),
        .sref_fire_o (sref_fire),
        .trip_o      (trip),
        .phase_rst_o (phase_rst),
        .stat_o      (stat)
    );

    nco_align_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (trip),
        .en_i   (irq_en),
        .clr_i  (irq_clr),
        .irq_o  (irq)
    );

    assign st_match = stat.match;
    assign st_pass  = stat.pass;
    assign st_fail  = stat.fail;

endmodule

// File: tb/nco_phase_align_tb_top.sv
module nco_phase_align_tb_top;
    localparam int DW = 16;
    localparam int TP = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] align_mode = 2'b00;
    logic align_arm_set = 0, lmfc_arm_set = 0, oneshot_sync = 0, ext_sysref_en = 1;
    logic sysref_in = 0, irq_en = 0, irq_clr = 0;
    logic [DW-1:0] key_i = 16'hA5A5, key_q = 16'h5A5A, smp_i = 0, smp_q = 0;
    logic phase_rst, st_match, st_pass, st_fail, irq;

    int checks = 0, errors = 0, pulses = 0, cyc = 0;

    // Reference model state.
    bit m_arm, m_lmfc, m_sprev, m_prst, m_match, m_pass, m_fail, m_irq;
    int m_cnt;

    always #5 clk = ~clk;

    nco_phase_align #(.DATA_W(DW), .TICK_PERIOD(TP)) dut_i (
        .clk(clk), .rst_n(rst_n), .align_mode(align_mode), .align_arm_set(align_arm_set),
        .lmfc_arm_set(lmfc_arm_set), .oneshot_sync(oneshot_sync), .ext_sysref_en(ext_sysref_en),
        .sysref_in(sysref_in), .key_i(key_i), .key_q(key_q), .smp_i(smp_i), .smp_q(smp_q),
        .irq_en(irq_en), .irq_clr(irq_clr), .phase_rst(phase_rst), .st_match(st_match),
        .st_pass(st_pass), .st_fail(st_fail), .irq(irq));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        bit sref, hit, fire, fail, trip;
        cyc++;
        if (!rst_n) begin
            m_arm = 0; m_lmfc = 0; m_sprev = 0; m_prst = 0;
            m_match = 0; m_pass = 0; m_fail = 0; m_irq = 0; m_cnt = 0;
        end else begin
            sref = ext_sysref_en ? (sysref_in && !m_sprev) : (m_cnt == TP - 1);
            if (oneshot_sync && !m_lmfc) sref = 0;
            hit  = (smp_i == key_i) && (smp_q == key_q);
            fire = 0; fail = 0;
            if (m_arm) begin
                if (align_mode == 2'b01)      fire = sref;
                else if (align_mode == 2'b10) fire = hit;
                else                          fail = sref || hit;
            end
            trip = fire || fail;
            if (align_arm_set) begin m_match = 0; m_pass = 0; m_fail = 0; end
            if (fire && align_mode == 2'b10) m_match = 1;
            if (fire) m_pass = 1;
            if (fail) m_fail = 1;
            if (lmfc_arm_set) m_lmfc = 1;
            else if (fire && align_mode == 2'b01) m_lmfc = 0;
            m_arm  = align_arm_set || (m_arm && !trip);
            m_prst = fire;
            if (trip) m_irq = 1; else if (irq_clr) m_irq = 0;
            m_sprev = sysref_in;
            m_cnt = (m_cnt == TP - 1) ? 0 : m_cnt + 1;
        end
    end

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (phase_rst) pulses++;
        chk("R3", "phase_rst", phase_rst, m_prst);
        chk("R8", "st_match", st_match, m_match);
        chk("R9", "st_pass", st_pass, m_pass);
        chk("R9", "st_fail", st_fail, m_fail);
        chk("R11", "irq", irq, m_irq && irq_en);
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #4; end
    endtask

    task automatic arm();
        align_arm_set = 1; step(); align_arm_set = 0; step();
    endtask

    task automatic sref_edge();
        sysref_in = 1; step(); sysref_in = 0; step();
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        step(3);
        // R1: reset state
        chk("R1", "phase_rst", phase_rst, 0); chk("R1", "st_pass", st_pass, 0);
        chk("R1", "st_fail", st_fail, 0);     chk("R1", "irq", irq, 0);
        rst_n = 1; step();

        // R2: an edge without arming does nothing
        align_mode = 2'b01; p0 = pulses; sref_edge(); step();
        chk("R2", "pulses unarmed", pulses - p0, 0);

        // R3: armed, the edge gives exactly one pulse the next cycle
        arm(); p0 = pulses; sysref_in = 1; step();
        chk("R3", "pulse after edge", phase_rst, 1);
        step(); chk("R3", "pulse width", phase_rst, 0);
        chk("R9", "pass", st_pass, 1);
        // R4: held high after re-arming does not retrigger
        arm(); step(4);
        chk("R4", "held level pulses", pulses - p0, 1);
        sysref_in = 0; step(); sysref_in = 1; step(2); sysref_in = 0;
        chk("R4", "new edge pulses", pulses - p0, 2);
        // R2: the arm cleared, so a later edge does nothing
        sref_edge(); step();
        chk("R2", "one pulse per arm", pulses - p0, 2);

        // R5: internal tick source ignores sysref_in
        ext_sysref_en = 0; arm(); p0 = pulses; step(TP + 2);
        chk("R5", "tick pulses", pulses - p0, 1);
        arm(); p0 = pulses; step(TP + 1);
        chk("R5", "tick pulses again", pulses - p0, 1);
        ext_sysref_en = 1;

        // R6: one-shot needs LMFC arming
        oneshot_sync = 1; arm(); p0 = pulses; sref_edge(); step();
        chk("R6", "no lmfc arming", pulses - p0, 0);
        lmfc_arm_set = 1; step(); lmfc_arm_set = 0; sref_edge(); step();
        chk("R6", "after lmfc arming", pulses - p0, 1);
        arm(); sref_edge(); step();
        chk("R6", "lmfc arming used up", pulses - p0, 1);
        oneshot_sync = 0; sref_edge(); step();
        chk("R6", "continuous policy", pulses - p0, 2);

        // R7: data pattern, partial matches ignored
        align_mode = 2'b10; arm(); p0 = pulses;
        smp_i = key_i; smp_q = 16'h0001; step();
        smp_i = 16'h0002; smp_q = key_q; step(); smp_q = 0; smp_i = 0; step();
        chk("R7", "partial hit pulses", pulses - p0, 0);
        chk("R8", "no match yet", st_match, 0);
        smp_i = key_i; smp_q = key_q; step(); smp_i = 0; smp_q = 0; step();
        chk("R7", "full hit pulses", pulses - p0, 1);
        chk("R8", "match", st_match, 1);

        // R9: invalid modes fail without a pulse
        align_mode = 2'b00; arm(); p0 = pulses;
        chk("R10", "status cleared by arm", st_match, 0);
        sref_edge();
        chk("R9", "fail mode 00", st_fail, 1); chk("R10", "pass cleared", st_pass, 0);
        align_mode = 2'b11; arm(); smp_i = key_i; smp_q = key_q; step(); smp_i = 0; smp_q = 0; step();
        chk("R9", "fail mode 11", st_fail, 1);
        align_mode = 2'b01; sref_edge(); step();
        chk("R9", "disarmed after fail", pulses - p0, 0);

        // R11: interrupt status, mask and clear
        irq_en = 1; step(); chk("R11", "irq pending", irq, 1);
        irq_en = 0; step(); chk("R11", "irq masked", irq, 0);
        irq_en = 1; irq_clr = 1; step(); irq_clr = 0; step();
        chk("R11", "irq cleared", irq, 0);
        arm(); sysref_in = 1; irq_clr = 1; step(); irq_clr = 0; sysref_in = 0; step();
        chk("R11", "trip beats clear", irq, 1);

        step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule